// File: doc/BRIEF.md
# Pause-Width Modulated Frame Transmitter

This block turns a short command word of up to 16 bits into the on/off pattern of a single carrier-enable line, for the reader-to-card direction of a proximity link. Every symbol opens with the same fixed carrier-off gap. The carrier then comes back on, and the symbol ends after a long or a short total period. The length of the symbol therefore carries the bit value. Once the last data bit has gone out, one more gap closes the frame. The carrier is then restored and a one-clock done pulse is raised. A reply receiver uses that pulse as the zero point for its own timing.

All durations are counted in ticks of a single-cycle tick-enable input. The surrounding logic can therefore set the symbol rate without touching the block. A frame starts with a start strobe that carries the data word and the bit count. Bits leave least significant first, and busy stays high until the frame has closed.

Top module: `pwtx_frame_tx`

## Requirements
- R1: After reset, carrier_o is 1, busy_o is 0 and done_o is 0.
- R2: A start_i pulse while busy_o is 0 is taken on that clock edge. In the following cycle busy_o is 1 and carrier_o is 0.
- R3: Each data symbol begins with carrier_o at 0 for exactly 30 counted ticks. The closing gap is also exactly 30 counted ticks.
- R4: A data bit of value 1 lasts 150 ticks from the start of its gap, so carrier_o is 1 for the last 120 ticks of the symbol.
- R5: A data bit of value 0 lasts 90 ticks from the start of its gap, so carrier_o is 1 for the last 60 ticks of the symbol.
- R6: The frame holds the number of bits given by the 5-bit binary nbits_i, sent from data_i bit 0 upward. A count of 0 sends 1 bit, and a count above 16 sends 16 bits.
- R7: After the last data bit comes the closing gap. On the edge that ends it, carrier_o returns to 1 and busy_o falls, and done_o is 1 for that single cycle only.
- R8: A start_i pulse while busy_o is 1 is ignored: the running frame and its data are unaffected and only one done pulse results.
- R9: Timing advances only on cycles with tick_i at 1. While tick_i stays 0, carrier_o and busy_o hold.
- R10: While idle, carrier_o stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle time-base enable |
| start_i | input | 1 | Frame start strobe |
| data_i | input | 16 | Frame bits, bit 0 sent first |
| nbits_i | input | 5 | Number of bits to send (1 to 16) |
| carrier_o | output | 1 | Carrier enable, 0 during gaps |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse when the frame closes |

## Verification
busy_o and the low carrier are due one cycle after the edge that samples start_i. Each carrier change is due on the very edge that consumes the 30th, 90th or 150th tick of a symbol, and done_o is due on the same edge as the final carrier restore. The bench drives the tick at the falling edge. At the same point it samples the carrier level that will be in force at the next rising edge. Each run is therefore measured in ticks the design actually consumes, whatever the tick spacing. Level checks on busy_o, carrier_o and done_o are taken one cycle after the start or done edge, with a 1 ns delay after the falling edge.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PAUSE = 2'd1,
        ST_MARK  = 2'd2,
        ST_TRAIL = 2'd3
    } tx_state_e;

endpackage

// File: rtl/pwtx_tick_count.sv
module pwtx_tick_count #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_reg_t;

    cnt_reg_t d, q;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.cnt = '0;
        end else if (inc_i) begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cnt_o = q.cnt;

    // R9: without an increment or clear the count holds
    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !inc_i) |=> $stable(cnt_o));

endmodule

// File: rtl/pwtx_bit_queue.sv
module pwtx_bit_queue #(
    parameter int unsigned MAX_BITS = 16,
    parameter int unsigned NB_W     = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                adv_i,
    input  logic [MAX_BITS-1:0] data_i,
    input  logic [NB_W-1:0]     nbits_i,
    output logic                cur_bit_o,
    output logic                last_o
);

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic [NB_W-1:0]     rem;
    } queue_reg_t;

    queue_reg_t d, q;
    logic [NB_W-1:0] nb_clamped;

    always_comb begin
        if (nbits_i == '0) begin
            nb_clamped = NB_W'(1);
        end else if (nbits_i > NB_W'(MAX_BITS)) begin
            nb_clamped = NB_W'(MAX_BITS);
        end else begin
            nb_clamped = nbits_i;
        end
    end

    always_comb begin
        d = q;
        if (load_i) begin
            d.data = data_i;
            d.rem  = nb_clamped;
        end else if (adv_i) begin
            d.data = q.data >> 1;
            d.rem  = q.rem - NB_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cur_bit_o = q.data[0];
    assign last_o    = (q.rem == NB_W'(1));

    // R6: remaining count never exceeds the maximum frame length
    p_rem_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.rem <= NB_W'(MAX_BITS));

    // R6: the controller never steps past the final bit
    p_adv_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> (q.rem > NB_W'(1)));

endmodule

// File: rtl/pwtx_frame_tx.sv
module pwtx_frame_tx
    import pwtx_pkg::*;
#(
    parameter int unsigned MAX_BITS = 16,
    parameter int unsigned PAUSE_T  = 30,
    parameter int unsigned ONE_T    = 150,
    parameter int unsigned ZERO_T   = 90,
    localparam int unsigned NB_W    = $clog2(MAX_BITS + 1),
    localparam int unsigned CNT_W   = $clog2(ONE_T)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                start_i,
    input  logic [MAX_BITS-1:0] data_i,
    input  logic [NB_W-1:0]     nbits_i,
    output logic                carrier_o,
    output logic                busy_o,
    output logic                done_o
);

    typedef struct packed {
        tx_state_e st;
        logic      car;
        logic      done;
    } ctl_reg_t;

    ctl_reg_t d, q;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             hit;
    logic             clr;
    logic             load;
    logic             adv;
    logic             cur_bit;
    logic             last_bit;

    pwtx_tick_count #(
        .CNT_W (CNT_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .inc_i (tick_i && (q.st != ST_IDLE)),
        .cnt_o (cnt)
    );

    pwtx_bit_queue #(
        .MAX_BITS (MAX_BITS),
        .NB_W     (NB_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .adv_i     (adv),
        .data_i    (data_i),
        .nbits_i   (nbits_i),
        .cur_bit_o (cur_bit),
        .last_o    (last_bit)
    );

    // Terminal count of the current phase
    always_comb begin
        if (q.st == ST_MARK) begin
            lim = cur_bit ? CNT_W'(ONE_T - 1) : CNT_W'(ZERO_T - 1);
        end else begin
            lim = CNT_W'(PAUSE_T - 1);
        end
    end

    assign hit = tick_i && (cnt == lim);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        clr    = 1'b0;
        load   = 1'b0;
        adv    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st  = ST_PAUSE;
                    d.car = 1'b0;
                    load  = 1'b1;
                    clr   = 1'b1;
                end
            end
            ST_PAUSE: begin
                if (hit) begin
                    d.st  = ST_MARK;
                    d.car = 1'b1;
                end
            end
            ST_MARK: begin
                if (hit) begin
                    clr   = 1'b1;
                    d.car = 1'b0;
                    if (last_bit) begin
                        d.st = ST_TRAIL;
                    end else begin
                        adv  = 1'b1;
                        d.st = ST_PAUSE;
                    end
                end
            end
            ST_TRAIL: begin
                if (hit) begin
                    clr    = 1'b1;
                    d.car  = 1'b1;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: begin
                d.st  = ST_IDLE;
                d.car = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.car  <= 1'b1;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign carrier_o = q.car;
    assign busy_o    = (q.st != ST_IDLE);
    assign done_o    = q.done;

    // R2: an accepted start opens the first gap on the next cycle
    p_start_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !carrier_o));

    // R3: the tick count stays inside the gap window during gaps
    p_pause_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PAUSE || q.st == ST_TRAIL) |-> (cnt < CNT_W'(PAUSE_T)));

    // R4: no symbol runs past the long symbol length
    p_symbol_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (cnt < CNT_W'(ONE_T)));

    // R7: done is a single cycle and coincides with carrier restore
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (carrier_o && !busy_o));

    // R8: a start during a frame does not restart it
    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !hit) |=> $stable(carrier_o));

    // R9: no tick, no change
    p_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_i) |=> ($stable(carrier_o) && $stable(busy_o)));

    // R10: idle carrier is on
    p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> carrier_o);

endmodule

// File: tb/sim_pwtx_frame_tx.sv
module sim_pwtx_frame_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] data_i = '0;
    logic [4:0]  nbits_i = '0;
    logic        carrier_o;
    logic        busy_o;
    logic        done_o;

    pwtx_frame_tx u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .start_i   (start_i),
        .data_i    (data_i),
        .nbits_i   (nbits_i),
        .carrier_o (carrier_o),
        .busy_o    (busy_o),
        .done_o    (done_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Tick driver and run-length monitor (one falling-edge process)
    int          tick_div = 1;
    int          phase = 0;
    logic        prev_car = 1'b1;
    int          run_ticks = 0;
    int          lows = 0;
    int          bad_low = 0;
    int          bad_high = 0;
    int          bits_seen = 0;
    logic [15:0] value_seen = '0;
    int          dones = 0;
    int          cycles = 0;

    always @(negedge clk) begin
        cycles++;
        if (tick_div == 0) begin
            tick_i = 1'b0;
        end else begin
            tick_i = (phase == 0);
            phase  = (phase + 1 >= tick_div) ? 0 : phase + 1;
        end
        if (done_o) dones++;
        if (carrier_o !== prev_car) begin
            if (prev_car == 1'b0) begin
                lows++;
                if (run_ticks != 30) bad_low++;
            end else if (run_ticks != 0) begin
                if (run_ticks == 120) begin
                    if (bits_seen < 16) value_seen[bits_seen] = 1'b1;
                end else if (run_ticks != 60) begin
                    bad_high++;
                end
                bits_seen++;
            end
            run_ticks = 0;
            prev_car  = carrier_o;
        end
        if (tick_i && (!carrier_o || busy_o)) run_ticks++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int eff_bits(input logic [4:0] nb);
        if (nb == 0) return 1;
        if (nb > 16) return 16;
        return int'(nb);
    endfunction

    task automatic start_frame(input logic [15:0] dat, input logic [4:0] nb);
        @(negedge clk); #1;
        lows = 0; bad_low = 0; bad_high = 0; bits_seen = 0;
        value_seen = '0; dones = 0; run_ticks = 0;
        data_i = dat; nbits_i = nb; start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic finish_frame(input logic [15:0] dat, input logic [4:0] nb);
        int n = 0;
        int eb = eff_bits(nb);
        logic [31:0] expv = {16'h0, dat} & ((32'h1 << eb) - 32'h1);
        while (dones == 0 && n < 40000) begin
            @(negedge clk); #1;
            n++;
        end
        chk("R7 done seen", 32'(dones), 32'd1);
        chk("R7 carrier restored with done", {29'd0, done_o, carrier_o, busy_o}, 32'b110);
        chk("R6 bit value", {16'h0, value_seen}, expv);
        chk("R6 bit count", 32'(bits_seen), 32'(eb));
        chk("R3 R7 gap count", 32'(lows), 32'(eb + 1));
        chk("R3 gap length", 32'(bad_low), 32'd0);
        chk("R4 R5 symbol length", 32'(bad_high), 32'd0);
        @(negedge clk); #1;
        chk("R7 done single cycle", {31'd0, done_o}, 32'd0);
    endtask

    localparam int NV = 7;
    localparam logic [15:0] V_DATA [NV] = '{16'h0055, 16'h0019, 16'hFFFF, 16'h0000,
                                            16'hA5C3, 16'h0001, 16'h8000};
    localparam logic [4:0]  V_NB   [NV] = '{5'd7, 5'd6, 5'd16, 5'd16, 5'd16, 5'd1, 5'd16};
    localparam int          V_DIV  [NV] = '{1, 1, 1, 2, 3, 1, 2};

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset carrier/busy/done", {29'd0, carrier_o, busy_o, done_o}, 32'b100);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 after release", {29'd0, carrier_o, busy_o, done_o}, 32'b100);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            tick_div = V_DIV[i];
            start_frame(V_DATA[i], V_NB[i]);
            chk("R2 busy and gap after start", {30'd0, busy_o, carrier_o}, 32'b10);
            finish_frame(V_DATA[i], V_NB[i]);
        end
        tick_div = 1;

        // R8: start while busy is ignored
        start_frame(16'h0003, 5'd2);
        repeat (100) @(negedge clk);
        #1;
        data_i = 16'hFFFF; nbits_i = 5'd16; start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        chk("R8 still busy after ignored start", {31'd0, busy_o}, 32'd1);
        finish_frame(16'h0003, 5'd2);

        // R6 count clamping
        start_frame(16'h0001, 5'd0);
        finish_frame(16'h0001, 5'd0);
        start_frame(16'hBEEF, 5'd31);
        finish_frame(16'hBEEF, 5'd31);

        // R9: no ticks means no progress
        tick_div = 0;
        start_frame(16'h0005, 5'd3);
        repeat (300) @(negedge clk);
        #1;
        chk("R9 held in gap without ticks", {30'd0, busy_o, carrier_o}, 32'b10);
        chk("R9 no ticks counted", 32'(run_ticks), 32'd0);
        tick_div = 1;
        finish_frame(16'h0005, 5'd3);

        // R10: idle carrier stays on
        begin
            int low_seen = 0;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk); #1;
                if (!carrier_o || busy_o) low_seen++;
            end
            chk("R10 idle carrier on", 32'(low_seen), 32'd0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule